// File: doc/BRIEF.md
# Regulator Timed Fault Supervisor

This block is the digital fault manager of a core voltage regulator controller that runs with one or two phases. External analog comparators report five conditions as single-bit flags: load current over the normal limit, load current over the fast-trip limit, current mismatch between the two phases, output too low, and output too high. The block qualifies each flag and turns a qualified fault into a shutdown. The normal overcurrent, undervoltage and overvoltage flags each have their own persistence counter. The fast-trip flag acts on its first sample. The imbalance flag is only considered while the two-phase mode is selected.

A qualified fault sets one sticky latch. The latch removes PWM enable, high-side and low-side switch enables and power-good together. It also stores a code for the condition that tripped it. Only a drop of the enable input or of the supply-good flag clears the latch. The cycle in which both inputs are high again produces a one-cycle soft-start request. The block also returns a registered one-phase indication, which the analog side uses to select its reduced thresholds (half the normal limit, two thirds of the fast-trip limit).

Top module: `vr_fault_sup`

## Requirements
- R1: After reset every output is 0. While `en_i` and `supply_ok_i` are both 1 and no fault is latched, `pwm_en_o`, `hs_en_o`, `ls_en_o` and `pgood_o` are 1 from the clock edge after both inputs were sampled high.
- R2: A fault latches at the edge where `oc_i` has been sampled 1 on OC_CYC consecutive edges (default 120). A single low sample restarts the count.
- R3: A single edge that samples `oc_fast_i` high while the block is running latches a fault at that edge, and the outputs go low there.
- R4: The imbalance flag latches a fault after IMB_CYC consecutive high samples (default 1000). This happens only while `two_phase_i` is 1. With `two_phase_i` at 0 its count is held at zero.
- R5: `uv_i` latches a fault after UV_CYC consecutive high samples (default 1000). This does not depend on the overcurrent flags.
- R6: `ov_i` latches a fault after OV_CYC consecutive high samples (default 1000).
- R7: A latched fault drives `pwm_en_o`, `hs_en_o`, `ls_en_o` and `pgood_o` to 0 together. They stay 0, with `cause_o` unchanged, for as long as enable and supply-good remain high, whatever the fault flags do.
- R8: The edge after `en_i` or `supply_ok_i` is sampled 0 clears the latch and sets `cause_o` to 0.
- R9: `softstart_o` is 1 for exactly one cycle, after the first edge that samples both `en_i` and `supply_ok_i` high following an edge where either was low (or following reset).
- R10: `one_phase_o` equals the inverse of `two_phase_i` sampled at the previous edge.
- R11: `cause_o` codes are 0 none, 1 fast-trip, 2 overcurrent, 3 imbalance, 4 undervoltage, 5 overvoltage. When several conditions qualify at the same edge, the lowest non-zero code is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (1 MHz tick assumed for default counts) |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Regulator enable |
| supply_ok_i | input | 1 | Controller supply above its minimum |
| two_phase_i | input | 1 | 1 selects two-phase operation |
| oc_i | input | 1 | Current above the normal limit |
| oc_fast_i | input | 1 | Current above the fast-trip limit |
| imbal_i | input | 1 | Phase current mismatch detected |
| uv_i | input | 1 | Output below the undervoltage limit |
| ov_i | input | 1 | Output above the overvoltage limit |
| pwm_en_o | output | 1 | PWM enable |
| hs_en_o | output | 1 | High-side switch enable |
| ls_en_o | output | 1 | Low-side switch enable |
| pgood_o | output | 1 | Power-good |
| softstart_o | output | 1 | Soft-start request pulse |
| one_phase_o | output | 1 | Selects reduced comparator thresholds |
| cause_o | output | 3 | Code of the first qualified fault |

## Verification
The overcurrent flag is held for one cycle less than its count and then dropped. This shows whether a counter fires early and whether it restarts instead of resuming. A long imbalance in one-phase mode, followed by the same imbalance in two-phase mode, shows whether the mode gates the check. Undervoltage and a fast-trip qualifying at the same edge show the cause priority. Fault flags raised while a fault is already latched show whether the stored cause is sticky. Clearing once through enable and once through supply-good shows that both release paths work and that each one produces the soft-start pulse.

// File: rtl/vrfs_pkg.sv
package vrfs_pkg;
  localparam int NUM_SRC = 5;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_FAST = 3'd1,
    CAUSE_OC   = 3'd2,
    CAUSE_IMB  = 3'd3,
    CAUSE_UV   = 3'd4,
    CAUSE_OV   = 3'd5
  } cause_e;
endpackage

// File: rtl/vrfs_persist.sv
// Consecutive-sample qualifier: hit is high on the LEN-th consecutive high sample.
module vrfs_persist #(
  parameter int unsigned LEN = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic flag,
  output logic hit
);
  localparam int unsigned W = $clog2(LEN + 1);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold || !flag) cnt <= '0;
    else if (cnt != LAST)     cnt <= cnt + 1'b1;
  end

  assign hit = flag && !hold && (cnt == LAST);
endmodule

// File: rtl/vrfs_cause_enc.sv
// Priority encoder: bit 0 has the highest priority and maps to code 1.
module vrfs_cause_enc
  import vrfs_pkg::*;
(
  input  logic [NUM_SRC-1:0] hit,
  output cause_e             cause
);
  always_comb begin
    cause = CAUSE_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit[i]) cause = cause_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/vr_fault_sup.sv
module vr_fault_sup
  import vrfs_pkg::*;
#(
  parameter int unsigned OC_CYC  = 120,
  parameter int unsigned IMB_CYC = 1000,
  parameter int unsigned UV_CYC  = 1000,
  parameter int unsigned OV_CYC  = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       supply_ok_i,
  input  logic       two_phase_i,
  input  logic       oc_i,
  input  logic       oc_fast_i,
  input  logic       imbal_i,
  input  logic       uv_i,
  input  logic       ov_i,
  output logic       pwm_en_o,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic       pgood_o,
  output logic       softstart_o,
  output logic       one_phase_o,
  output logic [2:0] cause_o
);
  localparam int NT = 4;
  localparam int unsigned TLEN [NT] = '{OC_CYC, IMB_CYC, UV_CYC, OV_CYC};

  logic           run, run_q, fault_q, fault_n, hold;
  logic [NT-1:0]  tflag, thit;
  logic [NUM_SRC-1:0] hits;
  cause_e         cause_q, cause_n, cause_enc;

  assign run   = en_i && supply_ok_i;
  assign hold  = !run || fault_q;
  assign tflag = {ov_i, uv_i, imbal_i && two_phase_i, oc_i};

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    vrfs_persist #(.LEN(TLEN[g])) u_tmr (
      .clk (clk),
      .rst (rst),
      .hold(hold),
      .flag(tflag[g]),
      .hit (thit[g])
    );
  end

  assign hits = {thit, oc_fast_i && !hold};

  vrfs_cause_enc u_enc (
    .hit  (hits),
    .cause(cause_enc)
  );

  always_comb begin
    fault_n = run && (fault_q || (|hits));
    if (!run)         cause_n = CAUSE_NONE;
    else if (fault_q) cause_n = cause_q;
    else              cause_n = cause_enc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q     <= 1'b0;
      cause_q     <= CAUSE_NONE;
      run_q       <= 1'b0;
      pwm_en_o    <= 1'b0;
      hs_en_o     <= 1'b0;
      ls_en_o     <= 1'b0;
      pgood_o     <= 1'b0;
      softstart_o <= 1'b0;
      one_phase_o <= 1'b0;
    end else begin
      fault_q     <= fault_n;
      cause_q     <= cause_n;
      run_q       <= run;
      pwm_en_o    <= run && !fault_n;
      hs_en_o     <= run && !fault_n;
      ls_en_o     <= run && !fault_n;
      pgood_o     <= run && !fault_n;
      softstart_o <= run && !run_q;
      one_phase_o <= !two_phase_i;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/vrfs_chk.sv
module vrfs_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_i,
  input logic       supply_ok_i,
  input logic       two_phase_i,
  input logic       oc_fast_i,
  input logic       pwm_en_o,
  input logic       hs_en_o,
  input logic       ls_en_o,
  input logic       pgood_o,
  input logic       softstart_o,
  input logic       one_phase_o,
  input logic [2:0] cause_o
);
  assert_fast_trip_R3: assert property (@(posedge clk) disable iff (rst)
    (en_i && supply_ok_i && oc_fast_i) |=> (!pwm_en_o && !pgood_o && cause_o != 3'd0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (cause_o != 3'd0 && en_i && supply_ok_i) |=> ($stable(cause_o) && !pwm_en_o && !pgood_o));

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    !(en_i && supply_ok_i) |=> (cause_o == 3'd0 && !pwm_en_o && !pgood_o));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    softstart_o |=> !softstart_o);

  assert_two_R10: assert property (@(posedge clk) disable iff (rst)
    two_phase_i |=> !one_phase_o);

  assert_one_R10: assert property (@(posedge clk) disable iff (rst)
    !two_phase_i |=> one_phase_o);

  assert_code_R11: assert property (@(posedge clk) disable iff (rst)
    cause_o <= 3'd5);

  always_comb begin
    if (!rst) begin
      assert_agree_R7: assert (pwm_en_o == hs_en_o && hs_en_o == ls_en_o && ls_en_o == pgood_o);
    end
  end
endmodule

bind vr_fault_sup vrfs_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .supply_ok_i(supply_ok_i),
  .two_phase_i(two_phase_i),
  .oc_fast_i  (oc_fast_i),
  .pwm_en_o   (pwm_en_o),
  .hs_en_o    (hs_en_o),
  .ls_en_o    (ls_en_o),
  .pgood_o    (pgood_o),
  .softstart_o(softstart_o),
  .one_phase_o(one_phase_o),
  .cause_o    (cause_o)
);

// File: tb/sim_vr_fault_sup.sv
module sim_vr_fault_sup;
  localparam int CLK_PERIOD = 10;
  localparam int OCN = 120;
  localparam int LN  = 1000;

  logic clk = 1'b0, rst = 1'b1;
  logic en = 0, sok = 0, two = 1, oc = 0, ocf = 0, imb = 0, uv = 0, ov = 0;
  logic pwm, hs, ls, pg, ss, one;
  logic [2:0] cause;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vr_fault_sup u0 (
    .clk(clk), .rst(rst), .en_i(en), .supply_ok_i(sok), .two_phase_i(two),
    .oc_i(oc), .oc_fast_i(ocf), .imbal_i(imb), .uv_i(uv), .ov_i(ov),
    .pwm_en_o(pwm), .hs_en_o(hs), .ls_en_o(ls), .pgood_o(pg),
    .softstart_o(ss), .one_phase_o(one), .cause_o(cause)
  );

  // Behavioural reference model
  int  c_oc, c_imb, c_uv, c_ov, m_cause;
  bit  m_fault, m_prev_run, e_on, e_ss, e_one;

  always @(posedge clk) begin
    if (rst) begin
      c_oc = 0; c_imb = 0; c_uv = 0; c_ov = 0; m_cause = 0;
      m_fault = 0; m_prev_run = 0; e_on = 0; e_ss = 0; e_one = 0;
    end else begin
      bit r, frozen;
      int pick;
      r = en && sok;
      frozen = !r || m_fault;
      pick = 0;
      if (!frozen) begin
        if (ov  && c_ov  == LN - 1)          pick = 5;
        if (uv  && c_uv  == LN - 1)          pick = 4;
        if (imb && two && c_imb == LN - 1)   pick = 3;
        if (oc  && c_oc  == OCN - 1)         pick = 2;
        if (ocf)                             pick = 1;
      end
      c_oc  = (frozen || !oc)         ? 0 : (c_oc  < OCN - 1 ? c_oc  + 1 : c_oc);
      c_imb = (frozen || !(imb && two)) ? 0 : (c_imb < LN - 1 ? c_imb + 1 : c_imb);
      c_uv  = (frozen || !uv)         ? 0 : (c_uv  < LN - 1 ? c_uv  + 1 : c_uv);
      c_ov  = (frozen || !ov)         ? 0 : (c_ov  < LN - 1 ? c_ov  + 1 : c_ov);
      if (!r) begin m_fault = 0; m_cause = 0; end
      else if (!m_fault && pick != 0) begin m_fault = 1; m_cause = pick; end
      e_on = r && !m_fault;
      e_ss = r && !m_prev_run;
      m_prev_run = r;
      e_one = !two;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(pwm == e_on, "R7 pwm_en", pwm, e_on);
      chk(hs == e_on && ls == e_on, "R7 switch enables", {hs, ls}, {e_on, e_on});
      chk(pg == e_on, "R1 pgood", pg, e_on);
      chk(ss == e_ss, "R9 softstart", ss, e_ss);
      chk(one == e_one, "R10 one_phase", one, e_one);
      chk(int'(cause) == m_cause, "R11 cause", cause, m_cause);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk(pwm == 0 && pg == 0 && cause == 0, "R1 reset state", pwm, 0);

    // Enable
    en = 1; sok = 1; two = 1;
    cyc(1);
    chk(ss == 1, "R9 pulse on start", ss, 1);
    chk(pwm == 1 && pg == 1, "R1 running", pwm, 1);

    // R2: one short of the count, then drop and retry
    oc = 1; cyc(OCN - 1);
    chk(pwm == 1, "R2 no early trip", pwm, 1);
    oc = 0; cyc(1);
    oc = 1; cyc(OCN - 1);
    chk(pwm == 1, "R2 restart after drop", pwm, 1);
    cyc(1);
    chk(pwm == 0 && cause == 3'd2, "R2 trip at count", cause, 2);
    oc = 0;

    // R8 clear through enable
    en = 0; cyc(1);
    chk(cause == 0 && pwm == 0, "R8 clear by enable", cause, 0);
    en = 1; cyc(1);
    chk(ss == 1 && pwm == 1, "R9 pulse after clear", ss, 1);

    // R3 fast trip
    ocf = 1; cyc(1);
    ocf = 0;
    chk(pwm == 0 && cause == 3'd1, "R3 fast trip", cause, 1);
    sok = 0; cyc(1);
    chk(cause == 0, "R8 clear by supply", cause, 0);
    sok = 1; cyc(1);

    // R4 imbalance gated by mode
    two = 0; imb = 1; cyc(LN + 200);
    chk(pwm == 1 && cause == 0, "R4 ignored in one-phase", cause, 0);
    chk(one == 1, "R10 one-phase indication", one, 1);
    two = 1; cyc(LN - 1);
    chk(pwm == 1, "R4 not yet", pwm, 1);
    cyc(1);
    chk(cause == 3'd3, "R4 imbalance trip", cause, 3);
    imb = 0; en = 0; cyc(1); en = 1; cyc(2);

    // R5 undervoltage
    uv = 1; cyc(LN);
    chk(cause == 3'd4 && pwm == 0, "R5 undervoltage trip", cause, 4);
    uv = 0; en = 0; cyc(1); en = 1; cyc(2);

    // R6 overvoltage
    ov = 1; cyc(LN - 1);
    chk(pwm == 1, "R6 not yet", pwm, 1);
    cyc(1);
    chk(cause == 3'd5, "R6 overvoltage trip", cause, 5);
    ov = 0; en = 0; cyc(1); en = 1; cyc(2);

    // R11 priority: undervoltage qualifies at the same edge as fast trip
    uv = 1; cyc(LN - 1);
    ocf = 1; cyc(1);
    ocf = 0; uv = 0;
    chk(cause == 3'd1, "R11 priority", cause, 1);

    // R7 sticky while latched
    ov = 1; oc = 1; cyc(LN + 50);
    chk(cause == 3'd1 && pwm == 0 && pg == 0, "R7 sticky latch", cause, 1);
    ov = 0; oc = 0;
    cyc(4);
    finish_run();
  end
endmodule